// File: doc/BRIEF.md
# Physical Address Space Router

This block decodes a 32-bit byte address on a processor-side bus and decides which memory region of a classic personal-computer address map serves it. Six regions are recognised: conventional RAM at the bottom, the display frame window, the option-card and expansion ROM window, the firmware ROM just below 1 MiB, extended RAM above 1 MiB, and a memory-mapped device window near the top of the 4 GiB space. The top 64 KiB of the space is a second view of the firmware ROM, so the fetch address a processor uses after reset lands in ROM.

For each request the block raises exactly one region select, or the unmapped flag when no region claims the address. It also provides the offset of the address inside the selected region and a per-region write strobe. Writes to read-only regions are dropped. The memories are outside the block. Each region returns its read byte on a shared input vector, and the router forwards the byte of the selected region. An unmapped read returns all ones. The extended RAM size, the device window base, whether the expansion window accepts writes, and whether the outputs are registered are all parameters.

Top module: `pc_addr_router`

## Requirements
- R1: Addresses 0x00000000 to 0x0009FFFF raise select bit 0 (low RAM), with offset equal to the address; the region accepts writes.
- R2: Addresses 0x000A0000 to 0x000BFFFF raise select bit 1 (display window), with offset equal to the address minus 0x000A0000; the region accepts writes.
- R3: Addresses 0x000C0000 to 0x000EFFFF raise select bit 2 (expansion window), with offset equal to the address minus 0x000C0000; with EXP_WRITABLE = 0 (default) a write there raises no write strobe.
- R4: Addresses 0x000F0000 to 0x000FFFFF raise select bit 3 (firmware ROM), with offset equal to the address minus 0x000F0000; write strobe bit 3 never rises.
- R5: Addresses from 0x00100000 up to but not including 0x00100000 + EXT_BYTES (default 10 MiB) raise select bit 4 (extended RAM), with offset equal to the address minus 0x00100000; the region accepts writes.
- R6: Addresses from DEV_BASE (default 0xF0000000) up to 0xFFFEFFFF raise select bit 5 (device window), with offset equal to the address minus DEV_BASE; the region accepts writes.
- R7: Addresses 0xFFFF0000 to 0xFFFFFFFF raise select bit 3 (firmware ROM alias), with offset equal to the address minus 0xFFFF0000, so 0xFFFFFFF0 gives offset 0xFFF0.
- R8: Any other address raises the unmapped flag with all select bits low, and the read data output is all ones.
- R9: At every cycle, including reset, exactly one of the six select bits and the unmapped flag is high.
- R10: A write strobe bit rises only for a request with both valid and write high whose region accepts writes; with REG_OUT = 1 (default) selects, unmapped flag, offset and write strobes show the request sampled at the previous rising clock edge.
- R11: The read data output equals byte r of the region read vector (bits 8r+7 down to 8r) when select bit r is high.
- R12: While reset is asserted the outputs are: all selects low, unmapped flag high, offset zero, write strobes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | Request is a write |
| req_addr | input | 32 | Physical byte address |
| region_rdata | input | 6*DATA_W | Read bytes returned by the regions, region r in slice r |
| sel_o | output | 6 | One-hot region select |
| unmapped_o | output | 1 | No region claims the address |
| offset_o | output | 32 | Address relative to the base of the selected region |
| we_o | output | 6 | Per-region write strobe, with writes to ROM regions removed |
| rdata_o | output | DATA_W | Read byte of the selected region, all ones when unmapped |

## Verification
The bench first walks the low 18 MiB in 2 KiB steps. This shows that each window below the extended RAM end sends the address to the correct select and gives the correct offset. It then probes the last and first byte on each side of every region edge, where an off-by-one compare or a wrong base would show. Coarse 16 MiB steps through the upper space separate the unmapped gap from the device window. Alternating reads, writes and idle requests show whether write strobes follow the region's write permission and the request qualifiers. The distinct byte that each region drives on the read vector shows whether the read mux picks the right slice.

// File: rtl/pc_map_pkg.sv
package pc_map_pkg;

   localparam int unsigned NREG   = 6;
   localparam int unsigned NRANGE = 7;

   typedef enum int unsigned {
      RG_LOW  = 0,
      RG_VGA  = 1,
      RG_EXP  = 2,
      RG_BIOS = 3,
      RG_EXT  = 4,
      RG_DEV  = 5
   } region_e;

   // Fixed boundaries, 33 bits wide so that the end of the 4 GiB space fits.
   localparam logic [32:0] LOW_TOP   = 33'h0_000A_0000;
   localparam logic [32:0] VGA_TOP   = 33'h0_000C_0000;
   localparam logic [32:0] EXP_TOP   = 33'h0_000F_0000;
   localparam logic [32:0] BIOS_TOP  = 33'h0_0010_0000;
   localparam logic [32:0] ALIAS_LO  = 33'h0_FFFF_0000;
   localparam logic [32:0] SPACE_TOP = 33'h1_0000_0000;

endpackage

// File: rtl/pc_range_match.sv
module pc_range_match #(
   parameter logic [32:0] LO = 33'h0,
   parameter logic [32:0] HI = 33'h1
) (
   input  logic [31:0] addr,
   output logic        hit
);
   import pc_map_pkg::*;

   logic [32:0] a_ext;
   assign a_ext = {1'b0, addr};

   if (HI <= LO) begin : g_bad_range
      $error("pc_range_match: empty range");
   end

   if (LO == 33'h0) begin : g_from_zero
      assign hit = (a_ext < HI);
   end else if (HI == SPACE_TOP) begin : g_to_top
      assign hit = (a_ext >= LO);
   end else begin : g_window
      assign hit = (a_ext >= LO) && (a_ext < HI);
   end

endmodule

// File: rtl/pc_region_decode.sv
module pc_region_decode #(
   parameter logic [31:0] EXT_BYTES = 32'h00A0_0000,
   parameter logic [31:0] DEV_BASE  = 32'hF000_0000
) (
   input  logic [31:0]                  addr,
   output logic [pc_map_pkg::NREG-1:0]  sel,
   output logic                         unmapped,
   output logic [31:0]                  offset
);
   import pc_map_pkg::*;

   localparam logic [32:0] EXT_LO = BIOS_TOP;
   localparam logic [32:0] EXT_HI = BIOS_TOP + {1'b0, EXT_BYTES};
   localparam logic [32:0] DEV_LO = {1'b0, DEV_BASE};

   function automatic logic [32:0] range_lo(int unsigned i);
      case (i)
         0:       return 33'h0;
         1:       return LOW_TOP;
         2:       return VGA_TOP;
         3:       return EXP_TOP;
         4:       return EXT_LO;
         5:       return DEV_LO;
         default: return ALIAS_LO;
      endcase
   endfunction

   function automatic logic [32:0] range_hi(int unsigned i);
      case (i)
         0:       return LOW_TOP;
         1:       return VGA_TOP;
         2:       return EXP_TOP;
         3:       return BIOS_TOP;
         4:       return EXT_HI;
         5:       return ALIAS_LO;
         default: return SPACE_TOP;
      endcase
   endfunction

   // Range 6 is the top-of-space alias of the firmware ROM.
   function automatic int unsigned range_region(int unsigned i);
      if (i == 6) return RG_BIOS;
      return i;
   endfunction

   logic [NRANGE-1:0] hit;

   for (genvar gi = 0; gi < NRANGE; gi++) begin : g_rng
      pc_range_match #(
         .LO (range_lo(gi)),
         .HI (range_hi(gi))
      ) u_match (
         .addr (addr),
         .hit  (hit[gi])
      );
   end

   logic [31:0] base;

   always_comb begin
      logic [32:0] lo_t;
      sel  = '0;
      base = '0;
      for (int unsigned i = 0; i < NRANGE; i++) begin
         lo_t = range_lo(i);
         if (hit[i]) begin
            sel[range_region(i)] = 1'b1;
            base = base | lo_t[31:0];
         end
      end
   end

   assign unmapped = ~|hit;
   assign offset   = addr - base;

endmodule

// File: rtl/pc_wr_gate.sv
module pc_wr_gate #(
   parameter logic [pc_map_pkg::NREG-1:0] WR_MASK = '1
) (
   input  logic                         valid,
   input  logic                         write,
   input  logic [pc_map_pkg::NREG-1:0]  sel,
   output logic [pc_map_pkg::NREG-1:0]  we
);
   import pc_map_pkg::*;

   for (genvar r = 0; r < NREG; r++) begin : g_we
      if (WR_MASK[r]) begin : g_rw
         assign we[r] = valid & write & sel[r];
      end else begin : g_ro
         assign we[r] = 1'b0;
      end
   end

endmodule

// File: rtl/pc_rdata_mux.sv
module pc_rdata_mux #(
   parameter int unsigned DATA_W = 8
) (
   input  logic [pc_map_pkg::NREG-1:0]         sel,
   input  logic                                unmapped,
   input  logic [pc_map_pkg::NREG*DATA_W-1:0]  region_rdata,
   output logic [DATA_W-1:0]                   rdata
);
   import pc_map_pkg::*;

   logic [DATA_W-1:0] picked;

   always_comb begin
      picked = '0;
      for (int unsigned r = 0; r < NREG; r++) begin
         picked = picked | (region_rdata[r*DATA_W +: DATA_W] & {DATA_W{sel[r]}});
      end
   end

   assign rdata = unmapped ? {DATA_W{1'b1}} : picked;

endmodule

// File: rtl/pc_addr_router.sv
module pc_addr_router #(
   parameter logic [31:0] EXT_BYTES    = 32'h00A0_0000,
   parameter logic [31:0] DEV_BASE     = 32'hF000_0000,
   parameter bit          EXP_WRITABLE = 1'b0,
   parameter bit          REG_OUT      = 1'b1,
   parameter int unsigned DATA_W       = 8
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic                                req_valid,
   input  logic                                req_write,
   input  logic [31:0]                         req_addr,
   input  logic [pc_map_pkg::NREG*DATA_W-1:0]  region_rdata,
   output logic [pc_map_pkg::NREG-1:0]         sel_o,
   output logic                                unmapped_o,
   output logic [31:0]                         offset_o,
   output logic [pc_map_pkg::NREG-1:0]         we_o,
   output logic [DATA_W-1:0]                   rdata_o
);
   import pc_map_pkg::*;

   localparam logic [32:0] EXT_END = BIOS_TOP + {1'b0, EXT_BYTES};
   localparam logic [NREG-1:0] WR_MASK =
      NREG'((1 << RG_LOW) | (1 << RG_VGA) | (1 << RG_EXT) | (1 << RG_DEV) |
            (int'(EXP_WRITABLE) << RG_EXP));

   if (EXT_BYTES == 32'h0) begin : g_chk_ext
      $error("pc_addr_router: EXT_BYTES must be non-zero");
   end
   if (EXT_END > {1'b0, DEV_BASE}) begin : g_chk_overlap
      $error("pc_addr_router: extended RAM overlaps the device window");
   end
   if ({1'b0, DEV_BASE} >= ALIAS_LO) begin : g_chk_dev
      $error("pc_addr_router: DEV_BASE must lie below the ROM alias");
   end
   if (DATA_W == 0) begin : g_chk_dw
      $error("pc_addr_router: DATA_W must be non-zero");
   end

   logic [NREG-1:0] dec_sel;
   logic            dec_unmapped;
   logic [31:0]     dec_offset;
   logic [NREG-1:0] dec_we;

   pc_region_decode #(
      .EXT_BYTES (EXT_BYTES),
      .DEV_BASE  (DEV_BASE)
   ) u_decode (
      .addr     (req_addr),
      .sel      (dec_sel),
      .unmapped (dec_unmapped),
      .offset   (dec_offset)
   );

   pc_wr_gate #(
      .WR_MASK (WR_MASK)
   ) u_wr_gate (
      .valid (req_valid),
      .write (req_write),
      .sel   (dec_sel),
      .we    (dec_we)
   );

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            sel_o      <= '0;
            unmapped_o <= 1'b1;
            offset_o   <= '0;
            we_o       <= '0;
         end else begin
            sel_o      <= dec_sel;
            unmapped_o <= dec_unmapped;
            offset_o   <= dec_offset;
            we_o       <= dec_we;
         end
      end
   end else begin : g_comb
      assign sel_o      = rst_n ? dec_sel      : '0;
      assign unmapped_o = rst_n ? dec_unmapped : 1'b1;
      assign offset_o   = rst_n ? dec_offset   : '0;
      assign we_o       = rst_n ? dec_we       : '0;
   end

   pc_rdata_mux #(
      .DATA_W (DATA_W)
   ) u_rmux (
      .sel          (sel_o),
      .unmapped     (unmapped_o),
      .region_rdata (region_rdata),
      .rdata        (rdata_o)
   );

endmodule

// File: rtl/pc_addr_router_chk.sv
module pc_addr_router_chk #(
   parameter bit          REG_OUT = 1'b1,
   parameter int unsigned DATA_W  = 8
) (
   input logic                         clk,
   input logic                         rst_n,
   input logic                         req_valid,
   input logic                         req_write,
   input logic [pc_map_pkg::NREG-1:0]  sel_o,
   input logic                         unmapped_o,
   input logic [31:0]                  offset_o,
   input logic [pc_map_pkg::NREG-1:0]  we_o,
   input logic [DATA_W-1:0]            rdata_o
);
   import pc_map_pkg::*;

   a_r9_one_owner: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({sel_o, unmapped_o}) == 1);

   a_r8_unmapped_ones: assert property (@(posedge clk) disable iff (!rst_n)
      unmapped_o |-> (rdata_o == {DATA_W{1'b1}}));

   a_r10_we_in_region: assert property (@(posedge clk) disable iff (!rst_n)
      (we_o & ~sel_o) == '0);

   a_r4_rom_no_write: assert property (@(posedge clk) disable iff (!rst_n)
      sel_o[RG_BIOS] |-> !we_o[RG_BIOS]);

   a_r7_rom_offset: assert property (@(posedge clk) disable iff (!rst_n)
      sel_o[RG_BIOS] |-> (offset_o < 32'h0001_0000));

   a_r1_low_offset: assert property (@(posedge clk) disable iff (!rst_n)
      sel_o[RG_LOW] |-> (offset_o < 32'h000A_0000));

   a_r2_vga_offset: assert property (@(posedge clk) disable iff (!rst_n)
      sel_o[RG_VGA] |-> (offset_o < 32'h0002_0000));

   if (REG_OUT) begin : g_reg
      a_r10_we_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
         (|we_o) |-> $past(req_valid && req_write));
   end else begin : g_comb
      a_r10_we_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
         (|we_o) |-> (req_valid && req_write));
   end

endmodule

bind pc_addr_router pc_addr_router_chk #(
   .REG_OUT (REG_OUT),
   .DATA_W  (DATA_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_valid  (req_valid),
   .req_write  (req_write),
   .sel_o      (sel_o),
   .unmapped_o (unmapped_o),
   .offset_o   (offset_o),
   .we_o       (we_o),
   .rdata_o    (rdata_o)
);

// File: tb/pc_addr_router_bench.sv
`timescale 1ns/1ps
module pc_addr_router_bench;
   localparam int NR = 6;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              req_valid = 1'b0;
   logic              req_write = 1'b0;
   logic [31:0]       req_addr = '0;
   logic [NR*8-1:0]   region_rdata;
   logic [NR-1:0]     sel_o;
   logic              unmapped_o;
   logic [31:0]       offset_o;
   logic [NR-1:0]     we_o;
   logic [7:0]        rdata_o;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   for (genvar r = 0; r < NR; r++) begin : g_rd
      assign region_rdata[r*8 +: 8] = 8'h30 + 8'(r);
   end

   pc_addr_router u_pc_addr_router (
      .clk          (clk),
      .rst_n        (rst_n),
      .req_valid    (req_valid),
      .req_write    (req_write),
      .req_addr     (req_addr),
      .region_rdata (region_rdata),
      .sel_o        (sel_o),
      .unmapped_o   (unmapped_o),
      .offset_o     (offset_o),
      .we_o         (we_o),
      .rdata_o      (rdata_o)
   );

   // Expected region from the requirements; -1 means unmapped (R8).
   function automatic int exp_region(longint a);
      if (a < 64'h000A0000) return 0;
      if (a < 64'h000C0000) return 1;
      if (a < 64'h000F0000) return 2;
      if (a < 64'h00100000) return 3;
      if (a < 64'h00B00000) return 4;
      if (a < 64'hF0000000) return -1;
      if (a < 64'hFFFF0000) return 5;
      return 3;
   endfunction

   function automatic longint exp_base(longint a);
      if (a < 64'h000A0000) return 0;
      if (a < 64'h000C0000) return 64'h000A0000;
      if (a < 64'h000F0000) return 64'h000C0000;
      if (a < 64'h00100000) return 64'h000F0000;
      if (a < 64'h00B00000) return 64'h00100000;
      if (a < 64'hF0000000) return 0;
      if (a < 64'hFFFF0000) return 64'hF0000000;
      return 64'hFFFF0000;
   endfunction

   function automatic string req_tag(longint a);
      int rg;
      rg = exp_region(a);
      if (a >= 64'hFFFF0000) return "R7";
      case (rg)
         0: return "R1";
         1: return "R2";
         2: return "R3";
         3: return "R4";
         4: return "R5";
         5: return "R6";
         default: return "R8";
      endcase
   endfunction

   task automatic chk(input logic [63:0] got, input logic [63:0] expv, input string tag, input string what);
      checks++;
      if (got !== expv) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, got, expv);
      end
   endtask

   // Drive at a falling edge, let one rising edge register it, check at the next falling edge.
   task automatic apply(input longint a, input bit v, input bit w);
      int rg;
      logic [NR-1:0] es;
      logic [NR-1:0] ew;
      logic [31:0]   eo;
      logic [7:0]    er;
      string tag;
      @(negedge clk);
      req_addr  = a[31:0];
      req_valid = v;
      req_write = w;
      @(negedge clk);
      rg  = exp_region(a);
      tag = req_tag(a);
      es  = '0;
      ew  = '0;
      if (rg >= 0) es[rg] = 1'b1;
      if (rg >= 0 && v && w && (rg == 0 || rg == 1 || rg == 4 || rg == 5)) ew[rg] = 1'b1;
      eo  = (rg >= 0) ? 32'(a - exp_base(a)) : offset_o;
      er  = (rg >= 0) ? 8'(8'h30 + rg) : 8'hFF;
      chk(64'(sel_o), 64'(es), tag, "select");
      chk(64'(unmapped_o), 64'(rg < 0), (rg < 0) ? "R8" : tag, "unmapped");
      if (rg >= 0) chk(64'(offset_o), 64'(eo), tag, "offset");
      chk(64'(we_o), 64'(ew), (rg == 2 || rg == 3) ? ((rg == 2) ? "R3" : "R4") : "R10", "write strobe");
      chk(64'(rdata_o), 64'(er), (rg < 0) ? "R8" : "R11", "read data");
      chk(64'($countones({sel_o, unmapped_o})), 64'd1, "R9", "owner count");
   endtask

   initial begin
      #1_000_000;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      req_addr = 32'h0009_0000;
      req_valid = 1'b1;
      req_write = 1'b1;
      repeat (3) @(negedge clk);
      // R12: reset state, request present but held in reset
      chk(64'(sel_o), 64'd0, "R12", "reset select");
      chk(64'(unmapped_o), 64'd1, "R12", "reset unmapped");
      chk(64'(offset_o), 64'd0, "R12", "reset offset");
      chk(64'(we_o), 64'd0, "R12", "reset write strobe");
      chk(64'($countones({sel_o, unmapped_o})), 64'd1, "R9", "reset owner count");
      @(negedge clk);
      rst_n = 1'b1;

      // R10: latency -- first edge after reset captures the held request.
      @(negedge clk);
      chk(64'(sel_o), 64'd1, "R10", "first captured select");
      chk(64'(we_o), 64'd1, "R10", "first captured write");

      // Sweep low 18 MiB: R1..R5, R8 gap start, R10, R11.
      for (longint a = 0; a < 64'h0120_0000; a += 64'h800) begin
         apply(a, 1'b1, a[11]);
      end

      // Region edges on both sides.
      begin
         longint edges [8] = '{64'h000A0000, 64'h000C0000, 64'h000F0000, 64'h00100000,
                               64'h00B00000, 64'hF0000000, 64'hFFFF0000, 64'hFFFFFFFF};
         for (int i = 0; i < 8; i++) begin
            apply(edges[i] - 1, 1'b1, 1'b1);
            apply(edges[i], 1'b1, 1'b1);
            apply(edges[i], 1'b1, 1'b0);
         end
      end

      // R7: reset fetch address maps to ROM offset 0xFFF0, write dropped.
      apply(64'hFFFFFFF0, 1'b1, 1'b1);
      chk(64'(offset_o), 64'hFFF0, "R7", "reset vector offset");
      chk(64'(sel_o), 64'h8, "R7", "reset vector select");
      apply(64'hFFFFFFF0, 1'b1, 1'b0);

      // Upper space coarse walk: R6, R8.
      for (longint a = 64'h0120_0000; a < 64'h1_0000_0000; a += 64'h0100_0000) begin
         apply(a, 1'b1, 1'b1);
         apply(a + 64'h00AB_CDEF, 1'b1, 1'b0);
      end

      // R10: write flag without valid, and valid read, raise no strobe.
      apply(64'h0000_1234, 1'b0, 1'b1);
      apply(64'h0050_0000, 1'b0, 1'b1);
      apply(64'hF123_4567, 1'b0, 1'b1);
      apply(64'h000A_8000, 1'b1, 1'b0);
      // R3 and R4: writes into read-only windows.
      apply(64'h000C_0000, 1'b1, 1'b1);
      apply(64'h000F_FFFF, 1'b1, 1'b1);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule